// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Bus

This block is an I2C target that gives a host controller access to a small configuration register file of 20 byte-wide locations. The 7-bit bus address has a fixed five-bit prefix and two low bits taken from strap pins, so four copies can share one bus. SCL and SDA are sampled with the system clock, synchronised and filtered before any edge is detected. The block drives SDA only through an output-enable that pulls the line low.

A write transfer carries the target address, then one byte that loads a register pointer, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps by one. A read transfer, normally issued after a repeated START that follows the pointer byte, returns bytes from the pointer onward with the same stepping. The register contents are exposed as a flat vector to the rest of the chip. Location 0x0C bit 0 requests an offset calibration: setting it produces a one-cycle strobe, and a done pulse from the calibration logic clears it.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target answers only the address {1,0,0,0,1,addr_sel[1],addr_sel[0]}, pulling SDA low in the acknowledge slot; any other address gets no acknowledge, and every following byte is ignored (no acknowledge, no register change) until the next START.
- R2: In a write transfer the first byte after the address loads the 5-bit pointer (bits 4:0, upper bits ignored); each later byte is stored at the pointer, acknowledged, and the pointer then increments, wrapping from 0x1F to 0x00.
- R3: In a read transfer (address LSB = 1) the target sends bytes MSB first from the pointer, incrementing it after each byte; after a controller acknowledge it sends the next byte, after a controller NACK it leaves SDA released until the next START.
- R4: A START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high; before any START the target neither acknowledges nor drives SDA, and after a STOP SDA is released.
- R5: Location 0x00 is read-only and reads {ID nibble, revision nibble} = 0x10 with default parameters; writes to it are acknowledged and ignored.
- R6: After reset location 0x01 holds 0x02, locations 0x06, 0x07 and 0x08 hold 0x40, and every other writable location holds 0x00.
- R7: Writes to locations 0x0D to 0x12 and 0x14 to 0x1F are acknowledged but change nothing; reads of them return 0x00.
- R8: When bit 0 of location 0x0C goes from 0 to 1, cal_go pulses high for exactly one cycle; a cal_done pulse clears that bit, leaving the other bits of 0x0C unchanged.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect on bus decoding.
- R10: regs_o carries location k in bits 8k+7 down to 8k for k = 0 to 19; SDA is changed by the target only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| addr_sel | input | 2 | Strap pins giving the two address LSBs |
| cal_done | input | 1 | Pulse from calibration logic, clears the start bit |
| cal_go | output | 1 | One-cycle calibration start strobe |
| regs_o | output | 160 | Flat register contents, location k at byte k |

## Verification
The embedded properties watch, on every cycle, that the data line is never pulled while the engine is idle or just after a STOP, that the pointer has advanced past every stored byte, that a filtered line only toggles after a run of equal samples, and that the calibration bit clears on a done pulse and its strobe lasts one cycle. Address matching over all 128 addresses and all strap settings, the contents of a wrapping 34-byte write burst, reads across the wrap and through reserved holes, silence after a NACK or before any START, and immunity to short glitches mid-byte are shown only by the bench's bus scenarios, which compare every byte with a model built from the reset defaults and the writable-location rules.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_PTR,
      PH_WR,
      PH_RD
   } phase_t;

   localparam int CFG_LOC       = 1;
   localparam int GAIN_FIRST    = 6;
   localparam int GAIN_LAST     = 8;
   localparam logic [7:0] CFG_RST  = 8'h02;
   localparam logic [7:0] GAIN_RST = 8'h40;

   function automatic logic [7:0] loc_default(int idx);
      if (idx == CFG_LOC) return CFG_RST;
      if (idx >= GAIN_FIRST && idx <= GAIN_LAST) return GAIN_RST;
      return 8'h00;
   endfunction

endpackage

// File: rtl/cfg_i2c_line_filt.sv
module cfg_i2c_line_filt #(
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (SYNC_LEN < 2) begin : g_bad_sync
         $error("SYNC_LEN must be at least 2");
      end
      if (FILT_LEN < 2) begin : g_bad_filt
         $error("FILT_LEN must be at least 2");
      end
   endgenerate

   logic [SYNC_LEN-1:0] sync_q;
   logic [FILT_LEN-1:0] hist_q;
   logic                out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         hist_q <= '1;
         out_q  <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_LEN-2:0], din};
         hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
         if (&hist_q)       out_q <= 1'b1;
         else if (~|hist_q) out_q <= 1'b0;
      end
   end

   assign dout = out_q;

   // R9: the filtered level moves only after a full run of equal samples
   p_filt_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |-> $past((&hist_q) || (~|hist_q)));

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
   import cfg_i2c_pkg::*;
#(
   parameter int         PTR_W      = 5,
   parameter logic [4:0] ADDR_FIXED = 5'b10001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_f,
   input  logic             sda_f,
   input  logic [1:0]       addr_sel,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   generate
      if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
         $error("PTR_W must lie in 1..8");
      end
   endgenerate

   localparam logic [3:0] ACK_SLOT  = 4'd8;
   localparam logic [3:0] ACK_DONE  = 4'd9;

   logic   scl_q, sda_q;
   logic   start_c, stop_c, rise_c, fall_c;
   phase_t phase;
   logic [3:0] bitcnt;
   logic [7:0] sh, tx;
   logic       rd_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign start_c = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;
   assign rise_c  = scl_f & ~scl_q;
   assign fall_c  = ~scl_f & scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         sh      <= '0;
         tx      <= '0;
         rd_go   <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_ptr  <= '0;
         wr_data <= '0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            phase  <= PH_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (rise_c) begin
               if (bitcnt < ACK_SLOT) begin
                  sh     <= {sh[6:0], sda_f};
                  bitcnt <= bitcnt + 4'd1;
               end else if (bitcnt == ACK_SLOT) begin
                  if (phase == PH_RD) rd_go <= ~sda_f;
                  bitcnt <= ACK_DONE;
               end
            end else if (fall_c) begin
               if (bitcnt == ACK_SLOT) begin
                  unique case (phase)
                     PH_ADDR: begin
                        if (sh[7:1] == {ADDR_FIXED, addr_sel}) begin
                           sda_oe <= 1'b1;
                           rd_go  <= 1'b1;
                           phase  <= sh[0] ? PH_RD : PH_PTR;
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end
                     PH_PTR: begin
                        sda_oe <= 1'b1;
                        ptr    <= sh[PTR_W-1:0];
                        phase  <= PH_WR;
                     end
                     PH_WR: begin
                        sda_oe  <= 1'b1;
                        wr_en   <= 1'b1;
                        wr_ptr  <= ptr;
                        wr_data <= sh;
                        ptr     <= ptr + 1'b1;
                     end
                     PH_RD:   sda_oe <= 1'b0;
                     default: ;
                  endcase
               end else if (bitcnt == ACK_DONE) begin
                  bitcnt <= '0;
                  sda_oe <= 1'b0;
                  if (phase == PH_RD) begin
                     if (rd_go) begin
                        tx     <= {rd_data[6:0], 1'b0};
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 1'b1;
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end
               end else if (phase == PH_RD && bitcnt != '0) begin
                  sda_oe <= ~tx[7];
                  tx     <= {tx[6:0], 1'b0};
               end
            end
         end
      end
   end

   // R4: an idle engine never holds the data line
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);
   // R4: a STOP releases the line
   p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !sda_oe);
   // R2: the pointer has moved past each stored byte
   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == wr_ptr + PTR_W'(1)));
   // R10: the target changes SDA only while SCL is low
   p_sda_low_scl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_f) || start_c || stop_c || $past(start_c || stop_c));

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
   import cfg_i2c_pkg::*;
#(
   parameter int         NUM_LOC = 20,
   parameter int         PTR_W   = 5,
   parameter logic [3:0] ID_NIB  = 4'h1,
   parameter logic [3:0] REV_NIB = 4'h0,
   parameter int         HOLE_LO = 13,
   parameter int         HOLE_HI = 18,
   parameter int         CAL_LOC = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PTR_W-1:0]   wr_ptr,
   input  logic [7:0]         wr_data,
   input  logic [PTR_W-1:0]   rd_ptr,
   input  logic               cal_done,
   output logic [7:0]         rd_data,
   output logic [NUM_LOC*8-1:0] regs_flat,
   output logic               cal_go
);
   localparam int SPACE = 1 << PTR_W;
   localparam int CAL_BIT = CAL_LOC * 8;

   generate
      if (NUM_LOC > SPACE || NUM_LOC <= CAL_LOC) begin : g_bad_size
         $error("NUM_LOC must fit the pointer space and cover CAL_LOC");
      end
   endgenerate

   logic cal_q;

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
      if (g == 0) begin : g_id
         assign regs_flat[7:0] = {ID_NIB, REV_NIB};
      end else if (g >= HOLE_LO && g <= HOLE_HI) begin : g_hole
         assign regs_flat[g*8 +: 8] = 8'h00;
      end else begin : g_store
         localparam logic [7:0] RST_VAL = loc_default(g);
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= RST_VAL;
            else if (wr_en && wr_ptr == PTR_W'(g))       q <= wr_data;
            else if (g == CAL_LOC && cal_done)           q[0] <= 1'b0;
         end
         assign regs_flat[g*8 +: 8] = q;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_LOC; i++)
         if (rd_ptr == PTR_W'(i)) rd_data = regs_flat[i*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q  <= 1'b0;
         cal_go <= 1'b0;
      end else begin
         cal_q  <= regs_flat[CAL_BIT];
         cal_go <= regs_flat[CAL_BIT] & ~cal_q;
      end
   end

   // R8: done pulse clears the start bit unless a write to it coincides
   p_cal_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !(wr_en && wr_ptr == PTR_W'(CAL_LOC))) |=> !regs_flat[CAL_BIT]);
   // R8: strobe lasts one cycle
   p_cal_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_go |=> !cal_go);
   // R2: a write to the configuration location lands there
   p_wr_land_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ptr == PTR_W'(CFG_LOC)) |=> (regs_flat[15:8] == $past(wr_data)));

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
   parameter int         SYNC_LEN   = 2,
   parameter int         FILT_LEN   = 3,
   parameter int         PTR_W      = 5,
   parameter int         NUM_LOC    = 20,
   parameter logic [4:0] ADDR_FIXED = 5'b10001,
   parameter logic [3:0] ID_NIB     = 4'h1,
   parameter logic [3:0] REV_NIB    = 4'h0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   input  logic [1:0]           addr_sel,
   input  logic                 cal_done,
   output logic                 cal_go,
   output logic [NUM_LOC*8-1:0] regs_o
);
   localparam int LINES = 2;

   logic [LINES-1:0] pad_in, filt_out;
   logic [PTR_W-1:0] ptr, wr_ptr;
   logic [7:0]       wr_data, rd_data;
   logic             wr_en;

   assign pad_in = {sda_i, scl_i};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      cfg_i2c_line_filt #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
         .clk(clk), .rst_n(rst_n), .din(pad_in[l]), .dout(filt_out[l]));
   end

   cfg_i2c_engine #(.PTR_W(PTR_W), .ADDR_FIXED(ADDR_FIXED)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_f(filt_out[0]), .sda_f(filt_out[1]),
      .addr_sel(addr_sel), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
      .wr_ptr(wr_ptr), .wr_data(wr_data), .sda_oe(sda_oe));

   cfg_i2c_regs #(.NUM_LOC(NUM_LOC), .PTR_W(PTR_W), .ID_NIB(ID_NIB),
                  .REV_NIB(REV_NIB)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
      .wr_data(wr_data), .rd_ptr(ptr), .cal_done(cal_done),
      .rd_data(rd_data), .regs_flat(regs_o), .cal_go(cal_go));

endmodule

// File: tb/tb_cfg_i2c_target.sv
module tb_cfg_i2c_target;
   localparam int Q = 5;
   localparam int NL = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] addr_sel = 2'b10;
   logic cal_done = 1'b0;
   logic sda_oe, cal_go, sda_line;
   logic [NL*8-1:0] regs_o;

   int n_chk = 0, n_fail = 0, n_go = 0;
   bit done = 0;
   logic [7:0] mdl [32];

   always #2.5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   cfg_i2c_target dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .cal_done(cal_done), .cal_go(cal_go),
      .regs_o(regs_o));

   always @(posedge clk) if (rst_n && cal_go) n_go++;

   function automatic logic [7:0] dflt(int i);
      if (i == 0) return 8'h10;
      if (i == 1) return 8'h02;
      if (i >= 6 && i <= 8) return 8'h40;
      return 8'h00;
   endfunction
   function automatic bit writable(int i);
      return i != 0 && i < NL && !(i >= 13 && i <= 18);
   endfunction
   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 5) & 8'hFE);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wclk(int n); repeat (n) @(negedge clk); endtask
   task automatic bstart; sda_m = 1; scl_m = 1; wclk(2*Q); sda_m = 0; wclk(2*Q); scl_m = 0; endtask
   task automatic brstart; wclk(Q); sda_m = 1; wclk(Q); scl_m = 1; wclk(2*Q); sda_m = 0; wclk(2*Q); scl_m = 0; endtask
   task automatic bstop; wclk(Q); sda_m = 0; wclk(Q); scl_m = 1; wclk(2*Q); sda_m = 1; wclk(2*Q); endtask
   task automatic bit_out(logic b); wclk(Q); sda_m = b; wclk(Q); scl_m = 1; wclk(2*Q); scl_m = 0; endtask
   task automatic bit_in(output logic v);
      wclk(Q); sda_m = 1; wclk(Q); scl_m = 1; wclk(Q); v = sda_line; wclk(Q); scl_m = 0;
   endtask
   task automatic wbyte(input logic [7:0] d, output bit ack);
      logic a;
      for (int b = 7; b >= 0; b--) bit_out(d[b]);
      bit_in(a); ack = !a;
   endtask
   task automatic rbyte(output logic [7:0] d, input bit mack);
      logic v;
      for (int b = 7; b >= 0; b--) begin bit_in(v); d[b] = v; end
      bit_out(!mack);
   endtask
   // byte with a short SCL pulse while low and a short SDA flip while high
   task automatic wbyte_glitch(input logic [7:0] d, output bit ack);
      logic a;
      for (int b = 7; b >= 0; b--) begin
         wclk(Q); sda_m = d[b];
         if (b == 4) begin scl_m = 1; wclk(2); scl_m = 0; wclk(Q - 2); end
         else wclk(Q);
         scl_m = 1;
         if (b == 2) begin wclk(Q - 1); sda_m = ~d[b]; wclk(2); sda_m = d[b]; wclk(Q - 1); end
         else wclk(2*Q);
         scl_m = 0;
      end
      bit_in(a); ack = !a;
   endtask

   task automatic check_regs(string req);
      for (int i = 0; i < NL; i++)
         chk(regs_o[i*8 +: 8] == mdl[i], req, $sformatf("regs_o loc %0d", i),
             int'(regs_o[i*8 +: 8]), int'(mdl[i]));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] d;
      for (int i = 0; i < 32; i++) mdl[i] = dflt(i);
      wclk(10); rst_n = 1; wclk(10);

      // R6 R5 R10: reset contents at their byte lanes
      check_regs("R6");
      chk(cal_go == 0 && sda_oe == 0, "R8", "idle strobe/oe", int'({cal_go, sda_oe}), 0);

      // R4: traffic before any START is ignored
      scl_m = 0; wclk(Q);
      wbyte(8'h8C, ack);
      chk(!ack, "R4", "ack before START", int'(ack), 0);
      bstop;

      // R1: all 128 addresses with straps 2'b10
      for (int a = 0; a < 128; a++) begin
         bstart; wbyte(8'(a << 1), ack); bstop;
         chk(ack == (a == 7'h46), "R1", $sformatf("ack for addr 0x%0h", a), int'(ack), int'(a == 7'h46));
      end
      // R1: every strap setting against the four candidate addresses
      for (int p = 0; p < 4; p++) begin
         addr_sel = 2'(p);
         for (int q = 0; q < 4; q++) begin
            bstart; wbyte({5'b10001, 2'(q), 1'b0}, ack); bstop;
            chk(ack == (p == q), "R1", $sformatf("strap %0d addr lsb %0d", p, q), int'(ack), int'(p == q));
         end
      end
      addr_sel = 2'b10;

      // R1: after a mismatch, further bytes are ignored
      bstart; wbyte(8'h8E, ack);
      chk(!ack, "R1", "mismatch ack", int'(ack), 0);
      wbyte(8'h09, ack); chk(!ack, "R1", "ptr after mismatch", int'(ack), 0);
      wbyte(8'h55, ack); chk(!ack, "R1", "data after mismatch", int'(ack), 0);
      bstop;
      check_regs("R1");

      // R2 R5 R7: 34-byte burst from pointer 0 wraps past 0x1F
      bstart; wbyte(8'h8C, ack); wbyte(8'hE0, ack);
      chk(ack, "R2", "pointer ack", int'(ack), 1);
      for (int i = 0; i < 34; i++) begin
         wbyte(pat(i), ack);
         if (writable(i & 31)) mdl[i & 31] = pat(i);
         chk(ack, (writable(i & 31) ? "R2" : "R7"), $sformatf("data ack %0d", i), int'(ack), 1);
      end
      bstop; wclk(4);
      check_regs("R2");
      chk(n_go == 0, "R8", "no strobe for even data", n_go, 0);

      // R3: read across the wrap, NACK, then silence until START
      bstart; wbyte(8'h8C, ack); wbyte(8'h1E, ack); brstart; wbyte(8'h8D, ack);
      chk(ack, "R3", "read addr ack", int'(ack), 1);
      for (int i = 0; i < 5; i++) begin
         rbyte(d, i != 4);
         chk(d == mdl[(30 + i) & 31], "R3", $sformatf("wrap read %0d", i), int'(d), int'(mdl[(30 + i) & 31]));
      end
      rbyte(d, 1'b0);
      chk(d == 8'hFF, "R3", "bus after NACK", int'(d), 8'hFF);
      bstop;

      // R3 R5 R7: full 32-location read from 0
      bstart; wbyte(8'h8C, ack); wbyte(8'h00, ack); brstart; wbyte(8'h8D, ack);
      for (int i = 0; i < 32; i++) begin
         rbyte(d, i != 31);
         chk(d == mdl[i], (i == 0 ? "R5" : (writable(i) ? "R3" : "R7")),
             $sformatf("read loc %0d", i), int'(d), int'(mdl[i]));
      end
      bstop;

      // R9: glitches inside a data byte are filtered out
      bstart; wbyte(8'h8C, ack); wbyte(8'h0A, ack); wbyte_glitch(8'h5A, ack);
      chk(ack, "R9", "ack after glitched byte", int'(ack), 1);
      bstop; mdl[10] = 8'h5A;
      chk(regs_o[10*8 +: 8] == 8'h5A, "R9", "glitched byte value", int'(regs_o[10*8 +: 8]), 8'h5A);

      // R8: start bit, strobe and clear
      bstart; wbyte(8'h8C, ack); wbyte(8'h0C, ack); wbyte(8'h03, ack); bstop; wclk(4);
      chk(regs_o[12*8 +: 8] == 8'h03, "R8", "cal loc set", int'(regs_o[12*8 +: 8]), 8'h03);
      chk(n_go == 1, "R8", "strobe count", n_go, 1);
      cal_done = 1; wclk(1); cal_done = 0; wclk(4);
      chk(regs_o[12*8 +: 8] == 8'h02, "R8", "cal loc cleared", int'(regs_o[12*8 +: 8]), 8'h02);
      chk(n_go == 1, "R8", "strobe count after clear", n_go, 1);
      bstart; wbyte(8'h8C, ack); wbyte(8'h0C, ack); brstart; wbyte(8'h8D, ack);
      rbyte(d, 1'b0); bstop;
      chk(d == 8'h02, "R8", "cal loc readback", int'(d), 8'h02);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule